// File: doc/BRIEF.md
# Presence-Vector Coherence Directory

This block is the coherence directory kept inside an inclusive last-level cache shared by several cores. Each of its entries, one per shared-cache line, holds a directory state (Uncached, Shared, Owned or Modified) and a presence vector with one bit per core. Cores send read misses and write misses. The directory then chooses one of several actions:

- reply straight away;
- fetch the line from memory;
- ask the owning core to write the line back;
- ask the owning core to pass the line to the requester and drop it;
- invalidate every other sharer, collect their acknowledgements, and then grant the line.

Transactions are handled one at a time, so each line never has more than one transaction open. A read that reaches a Modified line leaves the entry Owned rather than Shared.

All message channels use valid/ready. A sender raises valid with its payload and holds both unchanged until the cycle in which ready is also high; that cycle is the transfer. The directory lowers `req_ready` while it is busy, which back-pressures every core. The channels towards the caches and memory are held for as long as their ready stays low. Response messages that do not match what the open transaction is waiting for are accepted and dropped.

Top module: `coh_dir_top`

## Requirements
- R1: After reset every entry is Uncached with an empty presence vector, `req_ready` is 1, and `prb_valid`, `rpl_valid` and `mem_req_valid` are 0.
- R2: A read miss to an Uncached line raises one memory request for that line. After the fill it replies with `rpl_excl`=0, and the entry becomes Shared, holding only the requester.
- R3: A write miss to an Uncached line raises one memory request. After the fill it replies with `rpl_excl`=1, and the entry becomes Modified, owned by the requester.
- R4: A read miss to a Shared or Owned line replies with `rpl_excl`=0 without any probe or memory request. The requester's presence bit is added and the state is kept.
- R5: A read miss to a Modified line sends a Fetch probe (`prb_kind`=0) to the owner. It waits for a write-back response (`rsp_kind`=0) from that owner for that line, then replies with `rpl_excl`=0. The entry becomes Owned with the old owner and the requester present.
- R6: A write miss to a Modified line sends a Fetch-Invalidate probe (`prb_kind`=1) to the owner, with `prb_req` carrying the requester. The directory sends no reply. The entry stays Modified and its presence holds only the requester.
- R7: A write miss to a Shared or Owned line sends an Invalidate probe (`prb_kind`=2) to each present core except the requester, lowest core number first. After an acknowledgement (`rsp_kind`=1) from each of them, it replies with `rpl_excl`=1. The entry becomes Modified, holding only the requester.
- R8: A write miss to a Shared or Owned line whose only sharer is the requester replies with `rpl_excl`=1 at once, with no invalidations.
- R9: From the cycle a request is accepted until its transaction completes, `req_ready` stays 0.
- R10: While `prb_valid`, `rpl_valid` or `mem_req_valid` is high and its ready is low, that valid and its payload stay unchanged.
- R11: A response with the wrong kind, the wrong line, or a core that is not awaited is consumed without effect on the open transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core miss request valid |
| req_ready | output | 1 | Directory can accept a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_core | input | 2 | Requesting core |
| req_line | input | 4 | Directory entry index |
| prb_valid | output | 1 | Probe to a cache valid |
| prb_ready | input | 1 | Probe accepted |
| prb_kind | output | 2 | 0 Fetch, 1 Fetch-Invalidate, 2 Invalidate |
| prb_core | output | 2 | Destination core |
| prb_req | output | 2 | Core that caused the probe |
| prb_line | output | 4 | Line index |
| rsp_valid | input | 1 | Cache response valid |
| rsp_ready | output | 1 | Directory accepts a response |
| rsp_kind | input | 1 | 0 write-back, 1 invalidate acknowledgement |
| rsp_core | input | 2 | Responding core |
| rsp_line | input | 4 | Line index |
| rpl_valid | output | 1 | Data reply valid |
| rpl_ready | input | 1 | Reply accepted |
| rpl_core | output | 2 | Destination core |
| rpl_line | output | 4 | Line index |
| rpl_excl | output | 1 | 1 = granted Modified, 0 = granted Shared |
| mem_req_valid | output | 1 | Memory fetch request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_line | output | 4 | Line to fetch |
| mem_fill_valid | input | 1 | Memory fill valid |
| mem_fill_ready | output | 1 | Directory accepts fill |
| mem_fill_line | input | 4 | Line being filled |

## Verification
The bench walks one line through every state with the same sequence of cores. Each state is therefore observed only through later probes and replies, so a design that recorded the wrong presence vector would send invalidations or fetches to the wrong cores, and the scoreboard would catch the mismatch.

The invalidation fan-out is checked in two situations. One has the requester among the sharers, where a design that probed the requester itself would emit an extra Invalidate. The other has the requester as the sole sharer, where a wrong design would hang waiting for acknowledgements.

Responses are also sent with the wrong kind or the wrong line while a write-back is pending. A design that matched too loosely would reply early.

Probe back-pressure and a slow memory fill show whether payloads drift while ready is low and whether a second request slips in while the directory is busy.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_OWN = 2'd2,
    DS_MOD = 2'd3
  } dstate_e;

  typedef enum logic [1:0] {
    PK_FETCH = 2'd0,
    PK_FINV  = 2'd1,
    PK_INV   = 2'd2
  } pkind_e;

  localparam logic RK_WB  = 1'b0;
  localparam logic RK_ACK = 1'b1;

  typedef enum logic [3:0] {
    E_IDLE, E_DECIDE, E_MREQ, E_MWAIT, E_FETCH,
    E_WBWAIT, E_FINV, E_INV, E_ACKW, E_REPLY
  } phase_e;
endpackage

// File: rtl/low_pick.sv
module low_pick #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import coh_dir_pkg::*;
#(
  parameter int CORES = 4,
  parameter int LINES = 16,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    rd_idx,
  output dstate_e          rd_state,
  output logic [CORES-1:0] rd_pres,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_idx,
  input  dstate_e          wr_state,
  input  logic [CORES-1:0] wr_pres
);
  dstate_e          st_q [LINES];
  logic [CORES-1:0] pr_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= DS_UNC;
        pr_q[g] <= '0;
      end else if (wr_en && wr_idx == LW'(g)) begin
        st_q[g] <= wr_state;
        pr_q[g] <= wr_pres;
      end
    end

    a_r1_unc_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DS_UNC) |-> (pr_q[g] == '0));
    a_r6_mod_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DS_MOD) |-> $onehot(pr_q[g]));
    a_r5_owned_has_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DS_OWN) |-> ($countones(pr_q[g]) >= 2));
  end

  assign rd_state = st_q[rd_idx];
  assign rd_pres  = pr_q[rd_idx];
endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import coh_dir_pkg::*;
#(
  parameter int CORES = 4,
  parameter int LINES = 16,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [CW-1:0]    req_core,
  input  logic [LW-1:0]    req_line,
  output logic             prb_valid,
  input  logic             prb_ready,
  output logic [1:0]       prb_kind,
  output logic [CW-1:0]    prb_core,
  output logic [CW-1:0]    prb_req,
  output logic [LW-1:0]    prb_line,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             rsp_kind,
  input  logic [CW-1:0]    rsp_core,
  input  logic [LW-1:0]    rsp_line,
  output logic             rpl_valid,
  input  logic             rpl_ready,
  output logic [CW-1:0]    rpl_core,
  output logic [LW-1:0]    rpl_line,
  output logic             rpl_excl,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [LW-1:0]    mem_req_line,
  input  logic             mem_fill_valid,
  output logic             mem_fill_ready,
  input  logic [LW-1:0]    mem_fill_line,
  output logic [LW-1:0]    st_rd_idx,
  input  dstate_e          st_rd_state,
  input  logic [CORES-1:0] st_rd_pres,
  output logic             st_wr_en,
  output logic [LW-1:0]    st_wr_idx,
  output dstate_e          st_wr_state,
  output logic [CORES-1:0] st_wr_pres
);
  phase_e           ph_q;
  logic [CW-1:0]    cur_core_q, owner_q;
  logic [LW-1:0]    cur_line_q;
  logic             cur_wr_q;
  dstate_e          cur_st_q, new_st_q;
  logic [CORES-1:0] cur_pres_q, new_pres_q, tosend_q, await_q;

  logic [CORES-1:0] reqbit, others, inv_oh, rsp_oh;
  logic [CW-1:0]    own_idx, inv_idx;

  assign reqbit = CORES'(1) << cur_core_q;
  assign others = cur_pres_q & ~reqbit;
  assign inv_oh = CORES'(1) << inv_idx;
  assign rsp_oh = CORES'(1) << rsp_core;

  low_pick #(.W(CORES)) u_own (.mask(cur_pres_q), .idx(own_idx));
  low_pick #(.W(CORES)) u_inv (.mask(tosend_q),   .idx(inv_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= E_IDLE;
      cur_core_q <= '0;
      owner_q    <= '0;
      cur_line_q <= '0;
      cur_wr_q   <= 1'b0;
      cur_st_q   <= DS_UNC;
      new_st_q   <= DS_UNC;
      cur_pres_q <= '0;
      new_pres_q <= '0;
      tosend_q   <= '0;
      await_q    <= '0;
    end else begin
      unique case (ph_q)
        E_IDLE: if (req_valid) begin
          cur_core_q <= req_core;
          cur_line_q <= req_line;
          cur_wr_q   <= req_write;
          cur_st_q   <= st_rd_state;
          cur_pres_q <= st_rd_pres;
          ph_q       <= E_DECIDE;
        end
        E_DECIDE: begin
          owner_q <= own_idx;
          unique case (cur_st_q)
            DS_UNC: ph_q <= E_MREQ;
            DS_SHR, DS_OWN: begin
              if (!cur_wr_q) begin
                new_st_q   <= cur_st_q;
                new_pres_q <= cur_pres_q | reqbit;
                ph_q       <= E_REPLY;
              end else if (others == '0) begin
                new_st_q   <= DS_MOD;
                new_pres_q <= reqbit;
                ph_q       <= E_REPLY;
              end else begin
                tosend_q <= others;
                await_q  <= others;
                ph_q     <= E_INV;
              end
            end
            default: begin
              if (own_idx == cur_core_q) begin
                new_st_q   <= DS_MOD;
                new_pres_q <= cur_pres_q;
                ph_q       <= E_REPLY;
              end else begin
                ph_q <= cur_wr_q ? E_FINV : E_FETCH;
              end
            end
          endcase
        end
        E_MREQ: if (mem_req_ready) ph_q <= E_MWAIT;
        E_MWAIT: if (mem_fill_valid && mem_fill_line == cur_line_q) begin
          new_st_q   <= cur_wr_q ? DS_MOD : DS_SHR;
          new_pres_q <= reqbit;
          ph_q       <= E_REPLY;
        end
        E_FETCH: if (prb_ready) ph_q <= E_WBWAIT;
        E_WBWAIT: if (rsp_valid && rsp_kind == RK_WB && rsp_core == owner_q
                      && rsp_line == cur_line_q) begin
          new_st_q   <= DS_OWN;
          new_pres_q <= cur_pres_q | reqbit;
          ph_q       <= E_REPLY;
        end
        E_FINV: if (prb_ready) ph_q <= E_IDLE;
        E_INV: if (prb_ready) begin
          tosend_q <= tosend_q & ~inv_oh;
          if ((tosend_q & ~inv_oh) == '0) ph_q <= E_ACKW;
        end
        E_ACKW: if (rsp_valid && rsp_kind == RK_ACK && rsp_line == cur_line_q
                    && (await_q & rsp_oh) != '0) begin
          await_q <= await_q & ~rsp_oh;
          if ((await_q & ~rsp_oh) == '0) begin
            new_st_q   <= DS_MOD;
            new_pres_q <= reqbit;
            ph_q       <= E_REPLY;
          end
        end
        E_REPLY: if (rpl_ready) ph_q <= E_IDLE;
        default: ph_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    prb_kind = PK_FETCH;
    if (ph_q == E_FINV) prb_kind = PK_FINV;
    else if (ph_q == E_INV) prb_kind = PK_INV;
  end

  assign req_ready      = (ph_q == E_IDLE);
  assign prb_valid      = (ph_q == E_FETCH) || (ph_q == E_FINV) || (ph_q == E_INV);
  assign prb_core       = (ph_q == E_INV) ? inv_idx : owner_q;
  assign prb_req        = cur_core_q;
  assign prb_line       = cur_line_q;
  assign rsp_ready      = (ph_q == E_WBWAIT) || (ph_q == E_ACKW);
  assign rpl_valid      = (ph_q == E_REPLY);
  assign rpl_core       = cur_core_q;
  assign rpl_line       = cur_line_q;
  assign rpl_excl       = (new_st_q == DS_MOD);
  assign mem_req_valid  = (ph_q == E_MREQ);
  assign mem_req_line   = cur_line_q;
  assign mem_fill_ready = (ph_q == E_MWAIT);

  assign st_rd_idx   = req_line;
  assign st_wr_en    = (rpl_valid && rpl_ready) || (ph_q == E_FINV && prb_ready);
  assign st_wr_idx   = cur_line_q;
  assign st_wr_state = (ph_q == E_FINV) ? DS_MOD : new_st_q;
  assign st_wr_pres  = (ph_q == E_FINV) ? reqbit : new_pres_q;

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r10_probe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && !prb_ready) |=> (prb_valid && $stable(prb_core)
                                   && $stable(prb_kind) && $stable(prb_line)));
  a_r10_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_valid && !rpl_ready) |=> (rpl_valid && $stable(rpl_core)
                                   && $stable(rpl_excl) && $stable(rpl_line)));
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line)));
  a_r7_no_self_probe: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> (prb_core != prb_req));
  a_r7_inv_to_sharer: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_kind == PK_INV) |-> cur_pres_q[prb_core]);
endmodule

// File: rtl/coh_dir_top.sv
module coh_dir_top
  import coh_dir_pkg::*;
#(
  parameter int CORES = 4,
  parameter int LINES = 16,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [CW-1:0] req_core,
  input  logic [LW-1:0] req_line,
  output logic          prb_valid,
  input  logic          prb_ready,
  output logic [1:0]    prb_kind,
  output logic [CW-1:0] prb_core,
  output logic [CW-1:0] prb_req,
  output logic [LW-1:0] prb_line,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_kind,
  input  logic [CW-1:0] rsp_core,
  input  logic [LW-1:0] rsp_line,
  output logic          rpl_valid,
  input  logic          rpl_ready,
  output logic [CW-1:0] rpl_core,
  output logic [LW-1:0] rpl_line,
  output logic          rpl_excl,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [LW-1:0] mem_req_line,
  input  logic          mem_fill_valid,
  output logic          mem_fill_ready,
  input  logic [LW-1:0] mem_fill_line
);
  logic [LW-1:0]    rd_idx, wr_idx;
  dstate_e          rd_state, wr_state;
  logic [CORES-1:0] rd_pres, wr_pres;
  logic             wr_en;

  dir_store #(.CORES(CORES), .LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_state(rd_state), .rd_pres(rd_pres),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_pres(wr_pres)
  );

  dir_engine #(.CORES(CORES), .LINES(LINES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_core(req_core), .req_line(req_line),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind),
    .prb_core(prb_core), .prb_req(prb_req), .prb_line(prb_line),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_core(rsp_core), .rsp_line(rsp_line),
    .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_core(rpl_core),
    .rpl_line(rpl_line), .rpl_excl(rpl_excl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line),
    .mem_fill_valid(mem_fill_valid), .mem_fill_ready(mem_fill_ready),
    .mem_fill_line(mem_fill_line),
    .st_rd_idx(rd_idx), .st_rd_state(rd_state), .st_rd_pres(rd_pres),
    .st_wr_en(wr_en), .st_wr_idx(wr_idx), .st_wr_state(wr_state),
    .st_wr_pres(wr_pres)
  );
endmodule

// File: tb/sim_coh_dir_top.sv
module sim_coh_dir_top;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       req_valid, req_ready, req_write;
  logic [1:0] req_core;
  logic [3:0] req_line;
  logic       prb_valid, prb_ready;
  logic [1:0] prb_kind, prb_core, prb_req;
  logic [3:0] prb_line;
  logic       rsp_valid, rsp_ready, rsp_kind;
  logic [1:0] rsp_core;
  logic [3:0] rsp_line;
  logic       rpl_valid, rpl_ready, rpl_excl;
  logic [1:0] rpl_core;
  logic [3:0] rpl_line;
  logic       mem_req_valid, mem_req_ready;
  logic [3:0] mem_req_line;
  logic       mem_fill_valid, mem_fill_ready;
  logic [3:0] mem_fill_line;

  coh_dir_top u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit auto_rsp = 1;
  bit rsp_hs, fill_hs;
  int fill_delay = 8;

  logic [9:0] exp_prb [$];
  string      tag_prb [$];
  logic [6:0] exp_rpl [$];
  string      tag_rpl [$];
  logic [3:0] exp_mem [$];
  string      tag_mem [$];
  logic [6:0] resp_q [$];
  logic [3:0] fill_q [$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prb_valid && prb_ready) begin
        if (exp_prb.size() == 0) chk(0, "R7", "unexpected probe", {prb_kind, prb_core, prb_req, prb_line}, 0);
        else chk({prb_kind, prb_core, prb_req, prb_line} == exp_prb[0], tag_prb[0], "probe",
                 {prb_kind, prb_core, prb_req, prb_line}, exp_prb[0]);
        if (exp_prb.size() != 0) begin
          void'(exp_prb.pop_front());
          void'(tag_prb.pop_front());
        end
        if (auto_rsp && prb_kind == 2'd0) resp_q.push_back({1'b0, prb_core, prb_line});
        if (auto_rsp && prb_kind == 2'd2) resp_q.push_back({1'b1, prb_core, prb_line});
      end
      if (rpl_valid && rpl_ready) begin
        if (exp_rpl.size() == 0) chk(0, "R4", "unexpected reply", {rpl_core, rpl_line, rpl_excl}, 0);
        else begin
          chk({rpl_core, rpl_line, rpl_excl} == exp_rpl[0], tag_rpl[0], "reply",
              {rpl_core, rpl_line, rpl_excl}, exp_rpl[0]);
          void'(exp_rpl.pop_front());
          void'(tag_rpl.pop_front());
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        if (exp_mem.size() == 0) chk(0, "R4", "unexpected memory request", mem_req_line, 0);
        else begin
          chk(mem_req_line == exp_mem[0], tag_mem[0], "memory line", mem_req_line, exp_mem[0]);
          void'(exp_mem.pop_front());
          void'(tag_mem.pop_front());
        end
        fill_q.push_back(mem_req_line);
      end
      rsp_hs  = rsp_valid && rsp_ready;
      fill_hs = mem_fill_valid && mem_fill_ready;
    end
  end

  initial begin
    rsp_valid = 0; rsp_kind = 0; rsp_core = 0; rsp_line = 0;
    forever begin
      @(posedge clk); #1;
      if (rsp_valid && rsp_hs) rsp_valid = 0;
      if (!rsp_valid && resp_q.size() > 0) begin
        {rsp_kind, rsp_core, rsp_line} = resp_q.pop_front();
        rsp_valid = 1;
      end
    end
  end

  initial begin
    mem_fill_valid = 0; mem_fill_line = 0;
    forever begin
      @(posedge clk); #1;
      if (mem_fill_valid && fill_hs) mem_fill_valid = 0;
      if (!mem_fill_valid && fill_q.size() > 0) begin
        repeat (fill_delay) @(posedge clk);
        #1;
        mem_fill_line  = fill_q.pop_front();
        mem_fill_valid = 1;
      end
    end
  end

  task automatic send_req(bit w, int core, int line);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_core = 2'(core); req_line = 4'(line);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic settle(string tag);
    repeat (40) @(posedge clk);
    chk(exp_prb.size() == 0, tag, "probes outstanding", exp_prb.size(), 0);
    chk(exp_rpl.size() == 0, tag, "replies outstanding", exp_rpl.size(), 0);
    chk(exp_mem.size() == 0, tag, "memory requests outstanding", exp_mem.size(), 0);
  endtask

  task automatic want_prb(int kind, int core, int rq, int line, string tag);
    exp_prb.push_back({2'(kind), 2'(core), 2'(rq), 4'(line)});
    tag_prb.push_back(tag);
  endtask

  task automatic want_rpl(int core, int line, bit excl, string tag);
    exp_rpl.push_back({2'(core), 4'(line), excl});
    tag_rpl.push_back(tag);
  endtask

  task automatic want_mem(int line, string tag);
    exp_mem.push_back(4'(line));
    tag_mem.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_core = 0; req_line = 0;
    prb_ready = 1; rpl_ready = 1; mem_req_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
    chk(!prb_valid && !rpl_valid && !mem_req_valid, "R1", "valids after reset",
        {prb_valid, rpl_valid, mem_req_valid}, 0);

    // R2: read of an uncached line; R9 busy while the fill is slow
    want_mem(3, "R2"); want_rpl(0, 3, 0, "R2");
    send_req(0, 0, 3);
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R9", "req_ready during fill", req_ready, 0);
    settle("R2");

    // R4: read of a Shared line
    want_rpl(1, 3, 0, "R4");
    send_req(0, 1, 3);
    settle("R4");

    // R7 with probe back-pressure (R10)
    prb_ready = 0;
    want_prb(2, 0, 2, 3, "R7"); want_prb(2, 1, 2, 3, "R7"); want_rpl(2, 3, 1, "R7");
    send_req(1, 2, 3);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(prb_valid && prb_core == 2'd0 && prb_kind == 2'd2, "R10", "probe held",
          {prb_valid, prb_core, prb_kind}, {1'b1, 2'd0, 2'd2});
    end
    @(posedge clk); #1 prb_ready = 1;
    settle("R7");

    // R5 with stray responses (R11)
    auto_rsp = 0;
    resp_q.push_back({1'b1, 2'd2, 4'd3});
    resp_q.push_back({1'b0, 2'd2, 4'd4});
    want_prb(0, 2, 1, 3, "R5"); want_rpl(1, 3, 0, "R5");
    send_req(0, 1, 3);
    repeat (12) @(posedge clk);
    chk(exp_rpl.size() == 1, "R11", "reply before matching write-back", exp_rpl.size(), 1);
    resp_q.push_back({1'b0, 2'd2, 4'd3});
    settle("R5");
    auto_rsp = 1;

    // R4: read of an Owned line
    want_rpl(3, 3, 0, "R4");
    send_req(0, 3, 3);
    settle("R4");

    // R7: requester is a sharer; it is skipped
    want_prb(2, 2, 1, 3, "R7"); want_prb(2, 3, 1, 3, "R7"); want_rpl(1, 3, 1, "R7");
    send_req(1, 1, 3);
    settle("R7");

    // R6: write to Modified, no reply from the directory
    want_prb(1, 1, 0, 3, "R6");
    send_req(1, 0, 3);
    settle("R6");

    // R6 follow-up: the new owner is core 0
    want_prb(0, 0, 2, 3, "R6"); want_rpl(2, 3, 0, "R6");
    send_req(0, 2, 3);
    settle("R6");

    // R8: sole sharer upgrades without invalidations
    fill_delay = 2;
    want_mem(5, "R2"); want_rpl(2, 5, 0, "R2");
    send_req(0, 2, 5);
    settle("R2");
    want_rpl(2, 5, 1, "R8");
    send_req(1, 2, 5);
    settle("R8");

    // R3: write to an uncached line
    want_mem(9, "R3"); want_rpl(3, 9, 1, "R3");
    send_req(1, 3, 9);
    settle("R3");
    want_prb(0, 3, 0, 9, "R3"); want_rpl(0, 9, 0, "R3");
    send_req(0, 0, 9);
    settle("R3");

    finish_run();
  end
endmodule